// File: doc/BRIEF.md
# Accumulator Weighted Test Pattern Generator

This block produces built-in self-test stimulus for a circuit under test, one pattern on every clock. Its core is a plain W-bit adder accumulator: a session loads a start value S, then adds a fixed increment I once per clock, L times. The carry out of the top bit is dropped. The accumulator value after each addition is the pattern. Because the adder runs unmodified, the choice of I sets the weight of each pattern bit. Bits below the lowest set bit of I never change, so they hold the 0 or 1 taken from S. Bits from that position upward toggle pseudorandomly.

The sessions are stored as constant parameter tables (start, increment, length) inside the block. Sessions are executed in table order. A session whose length is zero is passed over. A pulse on `start` begins the sequence at session 0, and it also restarts a sequence that is already running. When the last session has finished, `done` goes high and stays high until the next `start`.

Top module: `acc_wpg`

## Requirements
- R1: After `start` is sampled high on clock edge k, the cycle following edge k+1 is the load cycle, with `valid` low. The first pattern, S0+I0, is shown with `valid` high after edge k+2.
- R2: Each successive pattern equals the previous pattern plus I, modulo 2^W. The carry out of the top bit is discarded.
- R3: Within a session of length L, `valid` is high for exactly L consecutive cycles. Between two non-empty sessions there is exactly one cycle with `valid` low.
- R4: A session with L = 0 emits no pattern and takes one load cycle before the next session is loaded.
- R5: Session k takes its start, increment and length from bits [k*W +: W] of `START_TAB`, [k*W +: W] of `STEP_TAB` and [k*LW +: LW] of `LEN_TAB`. Sessions run in increasing k.
- R6: `done` goes high in the same cycle as the last pattern of the last session. It then stays high with `valid` low until `start` is pulsed.
- R7: A `start` pulse during a run abandons that run and replays the whole sequence from session 0.
- R8: A synchronous active-high `rst` forces `valid`=0, `done`=0 and `pattern`=0 on the next cycle. The block stays idle until `start`.
- R9: In every session, pattern bits below the lowest set bit of I keep the value they have in S (weight 0 or 1). With I = 0, every bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts or restarts the session sequence |
| pattern | output | W | Current accumulator value, the test pattern |
| valid | output | 1 | High while `pattern` holds a fresh session pattern |
| done | output | 1 | High from the last pattern until the next start |

## Verification
All results are registered, so each is due a fixed number of edges after its cause. The first pattern appears two edges after `start`. Each later pattern appears one edge after the previous one. Each session boundary adds one edge, and each empty session adds one more. `done` rises on the edge that produces the last pattern. The bench turns the session tables into an expected cycle-by-cycle timeline of `valid`, `pattern`, constant-bit mask and `done`, counted from the edge that samples `start`. It then compares every cycle at the falling edge against that timeline. Two configurations are swept together: one with a wrapping session and an empty middle session, and a narrow one with an empty first session and a zero increment.

// File: rtl/acc_wpg.sv
module acc_wpg #(
  parameter int W      = 8,
  parameter int NSESS  = 4,
  parameter int LW     = 6,
  parameter logic [NSESS*W-1:0]  START_TAB = {8'h55, 8'hFE, 8'hF0, 8'h00},
  parameter logic [NSESS*W-1:0]  STEP_TAB  = {8'h80, 8'h03, 8'h10, 8'h01},
  parameter logic [NSESS*LW-1:0] LEN_TAB   = {6'd3, 6'd4, 6'd0, 6'd5}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] pattern,
  output logic         valid,
  output logic         done
);
  localparam int IW = (NSESS > 1) ? $clog2(NSESS) : 1;
  localparam logic [IW-1:0] LAST = IW'(NSESS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} st_t;

  st_t           st;
  logic [W-1:0]  acc;
  logic [LW-1:0] left;
  logic [IW-1:0] idx;

  logic [W-1:0]  cur_start, cur_step;
  logic [LW-1:0] cur_len;
  logic          at_last;

  assign cur_start = START_TAB[idx*W +: W];
  assign cur_step  = STEP_TAB[idx*W +: W];
  assign cur_len   = LEN_TAB[idx*LW +: LW];
  assign at_last   = (idx == LAST);
  assign pattern   = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      acc   <= '0;
      left  <= '0;
      idx   <= '0;
      valid <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      st    <= ST_LOAD;
      idx   <= '0;
      valid <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (st)
        ST_LOAD: begin
          valid <= 1'b0;
          if (cur_len == '0) begin
            if (at_last) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + IW'(1);
            end
          end else begin
            acc  <= cur_start;
            left <= cur_len;
            st   <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc   <= acc + cur_step;
          valid <= 1'b1;
          left  <= left - LW'(1);
          if (left == LW'(1)) begin
            if (at_last) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + IW'(1);
              st  <= ST_LOAD;
            end
          end
        end
        default: valid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/acc_wpg_chk.sv
module acc_wpg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] pattern,
  input logic         valid,
  input logic         done,
  input logic [W-1:0] step
);
  function automatic logic [W-1:0] hold_mask(input logic [W-1:0] inc);
    return (inc & (~inc + W'(1))) - W'(1);
  endfunction

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!valid && !done && pattern == '0));

  assert_load_gap_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (!valid && !done));

  assert_step_add_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> (pattern == W'($past(pattern) + $past(step))));

  assert_const_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |->
      (((pattern ^ $past(pattern)) & hold_mask($past(step))) == '0));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !valid);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

bind acc_wpg acc_wpg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .pattern(pattern),
  .valid(valid), .done(done), .step(cur_step)
);

// File: tb/tb_acc_wpg.sv
module tb_acc_wpg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] pat_a;
  logic [3:0] pat_b;
  logic v_a, d_a, v_b, d_b;
  int ntest = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  acc_wpg dut (
    .clk(clk), .rst(rst), .start(start),
    .pattern(pat_a), .valid(v_a), .done(d_a)
  );

  acc_wpg #(
    .W(4), .NSESS(3), .LW(3),
    .START_TAB({4'hA, 4'h3, 4'h0}),
    .STEP_TAB ({4'h4, 4'h0, 4'h0}),
    .LEN_TAB  ({3'd7, 3'd2, 3'd0})
  ) dut_b (
    .clk(clk), .rst(rst), .start(start),
    .pattern(pat_b), .valid(v_b), .done(d_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit b);
    int s[4], i[4], l[4];
    int ns, mask, t, donec, acc;
    int ev[128], ep[128], em[128], es[128];
    if (!b) begin
      s = '{'h00, 'hF0, 'hFE, 'h55}; i = '{'h01, 'h10, 'h03, 'h80};
      l = '{5, 0, 4, 3}; ns = 4; mask = 'hFF;
    end else begin
      s = '{'h0, 'h3, 'hA, 0}; i = '{'h0, 'h0, 'h4, 0};
      l = '{0, 2, 7, 0}; ns = 3; mask = 'hF;
    end
    for (int c = 0; c < 128; c++) begin ev[c] = 0; ep[c] = 0; em[c] = 0; es[c] = 0; end
    t = 1; donec = -1;
    for (int k = 0; k < ns; k++) begin
      if (l[k] == 0) t++;
      else begin
        acc = s[k];
        for (int j = 1; j <= l[k]; j++) begin
          acc = (acc + i[k]) & mask;
          ev[t+j] = 1; ep[t+j] = acc;
          em[t+j] = ((i[k] & -i[k]) - 1) & mask;
          es[t+j] = s[k];
        end
        t = t + l[k] + 1;
        donec = t - 1;
      end
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c <= t + 3; c++) begin
      int v, p, d;
      v = b ? int'(v_b) : int'(v_a);
      p = b ? int'(pat_b) : int'(pat_a);
      d = b ? int'(d_b) : int'(d_a);
      check(v == ev[c], (c == 2) ? "R1 first pattern" : "R3/R4 valid timeline", v, ev[c]);
      if (ev[c] != 0) begin
        check(p == ep[c], "R2/R5 pattern value", p, ep[c]);
        check((p & em[c]) == (es[c] & em[c]), "R9 constant bits", p & em[c], es[c] & em[c]);
      end
      check(d == int'(c >= donec), "R6 done", d, int'(c >= donec));
      @(negedge clk);
    end
    for (int c = 0; c < 6; c++) begin
      check((b ? v_b : v_a) == 1'b0, "R6 quiet after done", b ? v_b : v_a, 0);
      check((b ? d_b : d_a) == 1'b1, "R6 done held", b ? d_b : d_a, 1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(v_a == 0 && d_a == 0 && pat_a == 0, "R8 reset state", {v_a, d_a, pat_a}, 0);
    check(v_b == 0 && d_b == 0 && pat_b == 0, "R8 reset state b", {v_b, d_b, pat_b}, 0);
    repeat (4) @(negedge clk);
    check(v_a == 0 && d_a == 0, "R8 idle until start", {v_a, d_a}, 0);
    run_seq(1'b0);
    run_seq(1'b1);
    // R7: interrupt a run, then restart from session 0
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    run_seq(1'b0);
    // R8: reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(v_a == 0 && d_a == 0 && pat_a == 0, "R8 mid-run reset", {v_a, d_a, pat_a}, 0);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check(v_a == 0 && d_a == 0, "R8 stays idle", {v_a, d_a}, 0);
    end
    run_seq(1'b1);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    ntest++; nfail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule